// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit accumulator driven by one external pin. It works in one of two modes. In event mode it adds one for every qualifying transition on the pin. In gated mode it adds one for every tick of a bus-clock-divided-by-64 prescaler, but only while the pin sits at its active level. A single polarity bit selects the active transition in event mode and the active level in gated mode. When the block is disabled, the pin is left to ordinary I/O use and nothing counts.

Software works through a small register port. It can:
- read and preload the count,
- set the mode, polarity, enable and the two interrupt enables,
- see two sticky flags, each cleared by writing a one to it.

The overflow flag sets when the count wraps. The input-edge flag sets on a qualifying pin transition. The interrupt line is asserted while any flag is set together with its enable.

Top module: `pulse_acc`

## Requirements
- R1: After a synchronous reset the count, the control register and both flags read 0, and `irq_o` is low.
- R2: Register map on `reg_addr`:
  - Address 0 is the count.
  - Address 1 is control. Bit 0 is enable. Bit 1 is mode (0 event, 1 gated). Bit 2 is polarity. Bit 3 is the overflow interrupt enable. Bit 4 is the edge interrupt enable. Bits 7:5 read 0.
  - Address 2 holds the flags. Bit 0 is overflow and bit 1 is edge. Bits 7:2 read 0.
  - Address 3 reads 0 and ignores writes.
  - Reads are combinational. Writes take effect at the clock edge on which `reg_we` is high.
- R3: While enable is 0, pin activity changes neither the count nor either flag.
- R4: The pin passes through a two-flop synchronizer. A qualifying pin change first alters the count at the third rising clock edge after the change.
- R5: In event mode with polarity 0, each falling edge of the pin adds one to the count.
- R6: In event mode with polarity 1, each rising edge of the pin adds one to the count.
- R7: In gated mode with polarity 0, the count adds one on each prescaler tick while the synchronized pin is high. The prescaler emits one tick every 64 clocks. It runs freely from reset, and gate changes do not restart it.
- R8: In gated mode with polarity 1, the count adds one on each prescaler tick while the synchronized pin is low.
- R9: An increment from 0xFF wraps the count to 0x00 and sets the overflow flag.
- R10: The edge flag sets on a falling pin edge when polarity is 0, and on a rising pin edge when polarity is 1, in either mode. In gated mode this is the end of the active gate period.
- R11: Writing 1 to a flag bit at address 2 clears that flag, and writing 0 leaves it unchanged. A flag set event in the same cycle wins over the clear.
- R12: `irq_o` is high exactly when (overflow and its enable) or (edge flag and its enable).
- R13: A write to the count loads the written value. The write wins over a same-cycle increment, and that increment then sets no overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | External asynchronous pin |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The pin is driven with isolated single pulses in event mode under each polarity. Only the edges named by the polarity bit may count, which separates a rising-edge design from a falling-edge one. In gated mode, long high and long low windows that span several prescaler periods show level gating rather than edge counting, and show that ticks keep their 64-clock phase across gate changes. Further scenarios cover:
- a preload just below 0xFF, to reach the wrap;
- a count write and a flag clear placed on the very cycle of an increment, to expose priority mistakes;
- pin activity while disabled, to confirm nothing moves.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int PA_DATA_W   = 8;
    localparam int PA_PRESCALE = 64;

    localparam logic [1:0] PA_ADDR_CNT  = 2'd0;
    localparam logic [1:0] PA_ADDR_CTL  = 2'd1;
    localparam logic [1:0] PA_ADDR_FLAG = 2'd2;

    typedef enum logic {
        PA_EVENT = 1'b0,
        PA_GATED = 1'b1
    } pa_mode_e;

    typedef struct packed {
        logic     edge_ie;
        logic     ovf_ie;
        logic     pol;
        pa_mode_e mode;
        logic     en;
    } pa_ctl_t;

    typedef struct packed {
        logic edge_f;
        logic ovf_f;
    } pa_flags_t;

    localparam int PA_CTL_W  = $bits(pa_ctl_t);
    localparam int PA_FLAG_W = $bits(pa_flags_t);

    function automatic logic pa_pick_edge(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/pa_sync.sv
module pa_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o  = s2_q;
    assign rise_o = s2_q & ~s3_q;
    assign fall_o = ~s2_q & s3_q;

    // R4: a detected edge must reflect a pin change two cycles earlier
    p_rise_lag_r4: assert property (@(posedge clk) disable iff (rst)
        (rise_o && !$past(rst, 3)) |-> $past(pin_i, 2));

endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (DIV > 1) begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst || div_q == LAST) div_q <= '0;
                else                      div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);

            // R7: ticks are isolated, never on adjacent cycles
            p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pa_core.sv
module pa_core
    import pa_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pa_ctl_t          ctl,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             clr_we,
    input  pa_flags_t        clr_bits,
    output logic [CNT_W-1:0] count_o,
    output pa_flags_t        flags_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic act_edge, gate_on, inc, bump, wrap, edge_evt;
    logic [CNT_W-1:0] count_q;
    pa_flags_t        flags_q;

    always_comb begin
        act_edge = pa_pick_edge(ctl.pol, rise, fall);
        gate_on  = ctl.pol ? ~lvl : lvl;
        inc      = ctl.en && ((ctl.mode == PA_GATED) ? (tick && gate_on) : act_edge);
        bump     = inc && !cnt_we;
        wrap     = bump && (count_q == CNT_MAX);
        edge_evt = ctl.en && act_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            flags_q <= '0;
        end else begin
            if (cnt_we)    count_q <= cnt_wdata;
            else if (bump) count_q <= count_q + 1'b1;
            flags_q.ovf_f  <= wrap     | (flags_q.ovf_f  & ~(clr_we & clr_bits.ovf_f));
            flags_q.edge_f <= edge_evt | (flags_q.edge_f & ~(clr_we & clr_bits.edge_f));
        end
    end

    assign count_o = count_q;
    assign flags_o = flags_q;

    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !cnt_we) |=> (count_q == $past(count_q)));

    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && !cnt_we) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    p_ovf_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && !cnt_we && count_q == CNT_MAX) |=> (flags_q.ovf_f && count_q == '0));

    p_clear_ovf_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits.ovf_f && !wrap) |=> !flags_q.ovf_f);

    p_wr_wins_r13: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (count_q == $past(cnt_wdata)));

endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pa_pkg::*;
#(
    parameter int CNT_W    = PA_DATA_W,
    parameter int PRESCALE = PA_PRESCALE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_o
);
    localparam int CTL_PAD  = CNT_W - PA_CTL_W;
    localparam int FLAG_PAD = CNT_W - PA_FLAG_W;

    logic lvl, rise, fall, tick;
    logic cnt_we, ctl_we, clr_we;
    pa_ctl_t          ctl_q;
    pa_flags_t        flags;
    logic [CNT_W-1:0] count;

    assign cnt_we = reg_we && (reg_addr == PA_ADDR_CNT);
    assign ctl_we = reg_we && (reg_addr == PA_ADDR_CTL);
    assign clr_we = reg_we && (reg_addr == PA_ADDR_FLAG);

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= pa_ctl_t'(reg_wdata[PA_CTL_W-1:0]);
    end

    pa_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    pa_prescale #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pa_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_q),
        .lvl       (lvl),
        .rise      (rise),
        .fall      (fall),
        .tick      (tick),
        .cnt_we    (cnt_we),
        .cnt_wdata (reg_wdata),
        .clr_we    (clr_we),
        .clr_bits  (pa_flags_t'(reg_wdata[PA_FLAG_W-1:0])),
        .count_o   (count),
        .flags_o   (flags)
    );

    always_comb begin
        case (reg_addr)
            PA_ADDR_CNT:  reg_rdata = count;
            PA_ADDR_CTL:  reg_rdata = {{CTL_PAD{1'b0}}, ctl_q};
            PA_ADDR_FLAG: reg_rdata = {{FLAG_PAD{1'b0}}, flags};
            default:      reg_rdata = '0;
        endcase
    end

    assign irq_o = (flags.ovf_f & ctl_q.ovf_ie) | (flags.edge_f & ctl_q.edge_ie);

    p_ctl_readback_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_q == $past(reg_wdata[PA_CTL_W-1:0])));

    p_irq_needs_enable_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ovf_ie == 1'b0 && ctl_q.edge_ie == 1'b0) |-> !irq_o);

endmodule

// File: tb/pulse_acc_tb.sv
`timescale 1ns/1ps
module pulse_acc_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_i = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    always #10 clk = ~clk;

    pulse_acc u_dut (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    int    tests = 0;
    int    fails = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    rot = 0;

    // behavioural reference state
    int m_cnt, m_ctl, m_ovf, m_edge, m_div;
    int m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ctl = 0; m_ovf = 0; m_edge = 0; m_div = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int  en, gated, pol, act, gate, inc, cwr, wrapped;
            bit  rise, fall, tick;
            en    = m_ctl & 1;
            gated = (m_ctl >> 1) & 1;
            pol   = (m_ctl >> 2) & 1;
            rise  = (m_s2 == 1) && (m_s3 == 0);
            fall  = (m_s2 == 0) && (m_s3 == 1);
            tick  = (m_div == 63);
            act   = pol ? int'(rise) : int'(fall);
            gate  = pol ? int'(m_s2 == 0) : int'(m_s2 == 1);
            inc   = en && (gated ? (tick && gate) : act);
            cwr   = reg_we && reg_addr == 2'd0;
            wrapped = 0;
            if (cwr) m_cnt = reg_wdata;
            else if (inc) begin
                if (m_cnt == 255) wrapped = 1;
                m_cnt = (m_cnt + 1) % 256;
            end
            if (reg_we && reg_addr == 2'd2) begin
                if (reg_wdata[0]) m_ovf = 0;
                if (reg_wdata[1]) m_edge = 0;
            end
            if (wrapped) m_ovf = 1;
            if (en && act) m_edge = 1;
            if (reg_we && reg_addr == 2'd1) m_ctl = reg_wdata & 8'h1F;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_i;
            m_div = (m_div + 1) % 64;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            int exp_rd;
            bit exp_irq;
            case (reg_addr)
                2'd0:    exp_rd = m_cnt;
                2'd1:    exp_rd = m_ctl;
                2'd2:    exp_rd = (m_edge << 1) | m_ovf;
                default: exp_rd = 0;
            endcase
            exp_irq = (m_ovf && ((m_ctl >> 3) & 1)) || (m_edge && ((m_ctl >> 4) & 1));
            tests++;
            if (reg_rdata !== 8'(exp_rd) || irq_o !== exp_irq) begin
                fails++;
                $display("FAIL %s: addr %0d rdata %h irq %b, expected rdata %h irq %b",
                         cur_req, reg_addr, reg_rdata, irq_o, 8'(exp_rd), exp_irq);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            reg_we = 1'b0;
            reg_addr = 2'(rot);
            rot = (rot + 1) % 4;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    endtask

    task automatic pin_set(input logic v);
        @(posedge clk); #2;
        pin_i = v; reg_we = 1'b0;
        reg_addr = 2'(rot);
        rot = (rot + 1) % 4;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pin_set(1'b1); idle(hi);
            pin_set(1'b0); idle(lo);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        chk_on = 1'b1;
        cur_req = "R1"; idle(8);

        cur_req = "R3"; pulses(4, 5, 5); idle(6);

        cur_req = "R2";
        wr(2'd1, 8'hFE); idle(4);
        wr(2'd3, 8'hAA); idle(4);
        wr(2'd1, 8'h00); idle(4);

        cur_req = "R5"; wr(2'd1, 8'h19); idle(4);
        pulses(5, 6, 6); idle(6);

        cur_req = "R4";
        pin_set(1'b1); idle(5);
        pin_set(1'b0); idle(1);
        reg_addr = 2'd0; idle(0);
        @(posedge clk); #2 reg_addr = 2'd0;
        @(posedge clk); #2 reg_addr = 2'd0;
        idle(4);

        cur_req = "R11"; wr(2'd2, 8'h02); idle(4);

        cur_req = "R6"; wr(2'd1, 8'h1D); idle(4);
        pulses(4, 6, 6); idle(6);

        cur_req = "R13"; wr(2'd0, 8'hFD); idle(4);
        cur_req = "R9"; pulses(4, 6, 6); idle(6);

        cur_req = "R12"; wr(2'd1, 8'h05); idle(4);
        wr(2'd1, 8'h0D); idle(4);
        wr(2'd1, 8'h15); idle(4);

        cur_req = "R11";
        wr(2'd2, 8'h01); idle(4);
        wr(2'd2, 8'h00); idle(4);
        wr(2'd2, 8'h03); idle(4);

        cur_req = "R13";
        pin_set(1'b0); idle(4);
        pin_set(1'b1); idle(1);
        wr(2'd0, 8'h42); idle(6);

        cur_req = "R11";
        pin_set(1'b0); idle(4);
        pin_set(1'b1); idle(1);
        wr(2'd2, 8'h02); idle(6);

        cur_req = "R7"; wr(2'd1, 8'h1B); idle(10);
        pin_set(1'b1); idle(300);
        cur_req = "R10"; pin_set(1'b0); idle(200);

        cur_req = "R8"; wr(2'd2, 8'h03); wr(2'd1, 8'h1F); idle(10);
        pin_set(1'b1); idle(150);
        pin_set(1'b0); idle(300);
        cur_req = "R10"; pin_set(1'b1); idle(100);

        cur_req = "R9"; wr(2'd0, 8'hFE); idle(1);
        pin_set(1'b0); idle(200);
        pin_set(1'b1); idle(20);

        cur_req = "R3"; wr(2'd1, 8'h1E); idle(4);
        pulses(3, 5, 5); pin_set(1'b0); idle(150);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL R1 watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule